// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a processor core and a 32-bit, non-multiplexed external bus. The core hands it a single request: a read or write of one to four bytes at any byte address, or a four-long-word line read. The controller breaks the request into as many external bus cycles as the addressed device needs. It learns the device's width from that device's acknowledge on every cycle. Nothing about port widths is configured ahead of time.

A lane multiplexer places outgoing bytes so that an 8-, 16- or 32-bit device finds its bytes on the lanes it uses. Incoming bytes are gathered into a right-aligned big-endian result. One state machine covers three cycle types: handshake cycles with a size acknowledge, fast cycles with a synchronous acknowledge, and burst line reads that move one long word per clock after the first.

Top module: `bus_sizer`

## Requirements
- R1: After reset, or while no request is pending, `bus_cyc_o`, `bus_start_o`, `busy_o`, `ack_o` and `done_o` are low. A reset in the middle of a transfer abandons that transfer.
- R2: Each bus cycle drives `bus_len_o` with the number of bytes still owed, coded 01 = 1, 10 = 2, 11 = 3, 00 = 4, and drives `bus_addr_o` with the first unserved byte address.
- R3: A handshake cycle (ended by `port_ack_i`) takes at least three clocks: address, wait, then one idle clock. A synchronous cycle (ended by `sync_ack_i`) takes at least two clocks, and the next cycle may start on the following clock.
- R4: `port_ack_i` = 01 marks an 8-bit port that carries one byte on bits 31:24. The controller issues follow-on cycles until every requested byte has moved.
- R5: `port_ack_i` = 10 marks a 16-bit port on bits 31:16. A byte at an even address travels on bits 31:24 and a byte at an odd address on bits 23:16.
- R6: On a 32-bit port (`port_ack_i` = 11 or `sync_ack_i`), the byte at address offset k within the long word travels on lane 3-k (lane 3 is bits 31:24). An operand that crosses a long-word boundary takes two cycles.
- R7: Write data is placed so that the bytes of the current cycle sit on the lanes given in R4 to R6 for every possible port width at once.
- R8: For a line read, `burst_req_o` is raised on the first cycle. If the device ends that cycle with `sync_ack_i` and `burst_ack_i`, the remaining three long words are taken one per clock on each clock with `sync_ack_i` high, and a line read ends five clocks after its first address clock.
- R9: If a line read is not granted a burst, the remaining long words are fetched as ordinary single-word requests at the following long-word addresses, each sized by its own acknowledges.
- R10: `ack_o` pulses once per completed long word or operand, with `rdata_o` valid in the same cycle. An operand of N bytes is right-aligned, with its lowest-addressed byte most significant. `done_o` pulses together with the last `ack_o` of a request.
- R11: While neither acknowledge is present, the cycle stays in its wait phase with address and length unchanged. Each wait clock lengthens the cycle by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address of the operand |
| size_i | input | 2 | Operand bytes: 01 = 1, 10 = 2, 11 = 3, 00 = 4 |
| burst_i | input | 1 | Line read of four long words (read only, 16-byte aligned) |
| wdata_i | input | 32 | Right-aligned write operand |
| busy_o | output | 1 | Request in progress |
| ack_o | output | 1 | Long word or operand complete |
| done_o | output | 1 | Request complete |
| rdata_o | output | 32 | Read result, valid with `ack_o` |
| bus_addr_o | output | AW | External byte address |
| bus_len_o | output | 2 | Bytes still owed, coded as `size_i` |
| bus_read_o | output | 1 | 1 = read cycle |
| bus_start_o | output | 1 | Address clock of a new cycle |
| bus_cyc_o | output | 1 | Cycle active |
| bus_dout_o | output | 32 | Steered write data |
| bus_din_i | input | 32 | External read data |
| port_ack_i | input | 2 | Size acknowledge: 00 wait, 01 8-bit, 10 16-bit, 11 32-bit |
| sync_ack_i | input | 1 | Synchronous acknowledge, 32-bit port |
| burst_req_o | output | 1 | Burst requested on this cycle |
| burst_ack_i | input | 1 | Device accepts a burst |

## Verification
The device model counts clocks from each `bus_start_o`, and the bench predicts when the request should end. Each handshake cycle costs three clocks plus its wait clocks. Each synchronous cycle costs two clocks plus its wait clocks, and a granted burst finishes five clocks after its address clock. `done_o` and `ack_o` are registered, so the bench samples on falling edges and counts the clocks from the falling edge after the address clock to the falling edge where `done_o` is seen. The exact clock count, the number of cycles, and every cycle's address and length are each compared with values the bench derives from the requested address, length, port width and wait count.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WAIT, ST_END, ST_BURST
  } bs_state_e;

  // port width in bytes from the acknowledges; 0 = keep waiting
  function automatic logic [2:0] ack_width(logic [1:0] pa, logic sa);
    if (sa) return 3'd4;
    unique case (pa)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bus_sizer_wsteer.sv
module bus_sizer_wsteer
  import bus_sizer_pkg::*;
(
  input  logic [1:0]  lo_i,
  input  logic [2:0]  rem_i,
  input  logic [2:0]  off_i,
  input  logic [2:0]  nbytes_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] dout_o
);
  always_comb begin
    dout_o = '0;
    for (int l = 0; l < LANES; l++) begin
      int d32, d16, k, pos;
      d32 = LANES - 1 - l - int'(lo_i);
      d16 = LANES - 1 - l - int'(lo_i[0]);
      k   = -1;
      if (d32 >= 0 && d32 < int'(rem_i))            k = int'(off_i) + d32;
      else if (l >= 2 && d16 >= 0 && d16 < int'(rem_i)) k = int'(off_i) + d16;
      else if (l == LANES - 1)                       k = int'(off_i);
      pos = int'(nbytes_i) - 1 - k;
      if (k >= 0 && pos >= 0 && pos < LANES) dout_o[l*8 +: 8] = wdata_i[pos*8 +: 8];
    end
  end
endmodule

// File: rtl/bus_sizer_rmerge.sv
module bus_sizer_rmerge
  import bus_sizer_pkg::*;
(
  input  logic [1:0]  lo_i,
  input  logic [2:0]  pbytes_i,
  input  logic [2:0]  rem_i,
  input  logic [2:0]  off_i,
  input  logic [2:0]  nbytes_i,
  input  logic [31:0] din_i,
  input  logic [31:0] rbuf_i,
  output logic [31:0] merged_o,
  output logic [2:0]  taken_o
);
  always_comb begin
    int o, n;
    merged_o = rbuf_i;
    o = int'(lo_i) & (int'(pbytes_i) - 1);
    n = int'(pbytes_i) - o;
    if (int'(rem_i) < n) n = int'(rem_i);
    if (pbytes_i == 3'd0) n = 0;
    for (int i = 0; i < LANES; i++) begin
      int pos, lane;
      pos  = int'(nbytes_i) - 1 - int'(off_i) - i;
      lane = LANES - 1 - o - i;
      if (i < n && pos >= 0 && lane >= 0) merged_o[pos*8 +: 8] = din_i[lane*8 +: 8];
    end
    taken_o = 3'(n);
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          burst_i,
  input  logic [31:0]   wdata_i,
  output logic          busy_o,
  output logic          ack_o,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_len_o,
  output logic          bus_read_o,
  output logic          bus_start_o,
  output logic          bus_cyc_o,
  output logic [31:0]   bus_dout_o,
  input  logic [31:0]   bus_din_i,
  input  logic [1:0]    port_ack_i,
  input  logic          sync_ack_i,
  output logic          burst_req_o,
  input  logic          burst_ack_i
);
  localparam int LWW = $clog2(LINE_WORDS);
  localparam logic [LWW-1:0] LW_LAST = LWW'(LINE_WORDS - 1);

  bs_state_e       st_q;
  logic [AW-1:0]   base_q;
  logic            we_q, brst_q;
  logic [2:0]      nb_q, rem_q, off_q;
  logic [LWW-1:0]  lw_q;
  logic [31:0]     wdata_q, rbuf_q;

  logic [2:0]      pb, taken;
  logic [31:0]     merged, fin_data;
  logic            got_ack, burst_try, burst_go, item_done;
  logic [AW-1:0]   cur_addr;

  assign cur_addr = base_q + AW'({lw_q, 2'b00}) + AW'(off_q);
  assign pb       = ack_width(port_ack_i, sync_ack_i);
  assign got_ack  = (st_q == ST_WAIT) && (pb != 3'd0);
  assign burst_try = brst_q && (lw_q == '0) && (off_q == 3'd0);
  assign burst_go  = got_ack && sync_ack_i && burst_try && burst_ack_i;
  assign item_done = (got_ack && sync_ack_i && !burst_go && (rem_q == taken))
                   || ((st_q == ST_END) && (rem_q == 3'd0));
  assign fin_data  = (st_q == ST_END) ? rbuf_q : merged;

  bus_sizer_rmerge u_rmerge (
    .lo_i     (cur_addr[1:0]),
    .pbytes_i (pb),
    .rem_i    (rem_q),
    .off_i    (off_q),
    .nbytes_i (nb_q),
    .din_i    (bus_din_i),
    .rbuf_i   (rbuf_q),
    .merged_o (merged),
    .taken_o  (taken)
  );

  bus_sizer_wsteer u_wsteer (
    .lo_i     (cur_addr[1:0]),
    .rem_i    (rem_q),
    .off_i    (off_q),
    .nbytes_i (nb_q),
    .wdata_i  (wdata_q),
    .dout_o   (bus_dout_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign bus_addr_o  = cur_addr;
  assign bus_len_o   = rem_q[1:0];
  assign bus_read_o  = !we_q;
  assign bus_start_o = (st_q == ST_ADDR);
  assign bus_cyc_o   = (st_q == ST_ADDR) || (st_q == ST_WAIT) || (st_q == ST_BURST);
  assign burst_req_o = burst_try && ((st_q == ST_ADDR) || (st_q == ST_WAIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      we_q    <= 1'b0;
      brst_q  <= 1'b0;
      nb_q    <= 3'd0;
      rem_q   <= 3'd0;
      off_q   <= 3'd0;
      lw_q    <= '0;
      wdata_q <= '0;
      rbuf_q  <= '0;
      rdata_o <= '0;
      ack_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      ack_o  <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          base_q  <= addr_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          nb_q    <= (size_i == 2'b00) ? 3'd4 : {1'b0, size_i};
          rem_q   <= (size_i == 2'b00) ? 3'd4 : {1'b0, size_i};
          off_q   <= 3'd0;
          lw_q    <= '0;
          brst_q  <= burst_i && !we_i;
          rbuf_q  <= '0;
          st_q    <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_WAIT;
        ST_WAIT: if (got_ack) begin
          rbuf_q <= merged;
          rem_q  <= rem_q - taken;
          off_q  <= off_q + taken;
          if (!sync_ack_i) st_q <= ST_END;
          else if (burst_go) begin
            rdata_o <= merged;
            ack_o   <= 1'b1;
            lw_q    <= lw_q + 1'b1;
            rem_q   <= 3'd4;
            off_q   <= 3'd0;
            st_q    <= ST_BURST;
          end else st_q <= ST_ADDR;
        end
        ST_END: st_q <= ST_ADDR;
        ST_BURST: if (sync_ack_i) begin
          rdata_o <= bus_din_i;
          ack_o   <= 1'b1;
          if (lw_q == LW_LAST) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else lw_q <= lw_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (item_done) begin
        rdata_o <= fin_data;
        ack_o   <= 1'b1;
        if (brst_q && lw_q != LW_LAST) begin
          lw_q  <= lw_q + 1'b1;
          rem_q <= 3'd4;
          off_q <= 3'd0;
          st_q  <= ST_ADDR;
        end else begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk
  import bus_sizer_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input bs_state_e     st_q,
  input logic          bus_start_o,
  input logic          bus_cyc_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_len_o,
  input logic          bus_read_o,
  input logic          burst_req_o,
  input logic          busy_o,
  input logic          ack_o,
  input logic          done_o
);
  assert_wait_follows_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |=> (bus_cyc_o && !bus_start_o));

  assert_wait_holds_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && $past(st_q) == ST_WAIT) |-> ($stable(bus_addr_o) && $stable(bus_len_o)));

  assert_done_with_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ack_o);

  assert_ack_after_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(busy_o));

  assert_burst_only_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o |-> (bus_read_o && bus_cyc_o));
endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_q        (st_q),
  .bus_start_o (bus_start_o),
  .bus_cyc_o   (bus_cyc_o),
  .bus_addr_o  (bus_addr_o),
  .bus_len_o   (bus_len_o),
  .bus_read_o  (bus_read_o),
  .burst_req_o (burst_req_o),
  .busy_o      (busy_o),
  .ack_o       (ack_o),
  .done_o      (done_o)
);

// File: tb/bus_sizer_tb_top.sv
module bus_sizer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;

  typedef struct packed {
    logic       we;
    logic [3:0] lo;
    logic [1:0] sz;
    logic       bst;
    logic [2:0] pw;
    logic       syn;
    logic [1:0] wt;
    logic       bk;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 2'd0, 1'b0, 3'd4, 1'b1, 2'd0, 1'b0},
    '{1'b0, 4'd0, 2'd0, 1'b0, 3'd4, 1'b0, 2'd1, 1'b0},
    '{1'b0, 4'd0, 2'd0, 1'b0, 3'd1, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd1, 2'd0, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd1, 2'd0, 1'b0, 3'd4, 1'b1, 2'd0, 1'b0},
    '{1'b0, 4'd3, 2'd2, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd2, 2'd1, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd5, 2'd3, 1'b0, 3'd1, 1'b0, 2'd2, 1'b0},
    '{1'b1, 4'd0, 2'd0, 1'b0, 3'd1, 1'b0, 2'd0, 1'b0},
    '{1'b1, 4'd1, 2'd3, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0},
    '{1'b1, 4'd2, 2'd2, 1'b0, 3'd4, 1'b1, 2'd0, 1'b0},
    '{1'b0, 4'd0, 2'd0, 1'b1, 3'd4, 1'b1, 2'd0, 1'b1},
    '{1'b0, 4'd0, 2'd0, 1'b1, 3'd4, 1'b1, 2'd0, 1'b0},
    '{1'b0, 4'd0, 2'd0, 1'b1, 3'd2, 1'b0, 2'd0, 1'b0},
    '{1'b1, 4'd3, 2'd0, 1'b0, 3'd4, 1'b0, 2'd1, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R2";
      1:  return "R11";
      2:  return "R4";
      3:  return "R5";
      4:  return "R6";
      5:  return "R10";
      6:  return "R5";
      7:  return "R3";
      8:  return "R7";
      9:  return "R7";
      10: return "R7";
      11: return "R8";
      12: return "R9";
      13: return "R9";
      default: return "R6";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, burst_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [1:0]  size_i = '0;
  logic busy_o, ack_o, done_o, bus_read_o, bus_start_o, bus_cyc_o, burst_req_o;
  logic [31:0] rdata_o, bus_addr_o, bus_dout_o;
  logic [1:0]  bus_len_o;
  logic [31:0] bus_din_i = '0;
  logic [1:0]  port_ack_i = '0;
  logic sync_ack_i = 1'b0, burst_ack_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sizer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .burst_i(burst_i), .wdata_i(wdata_i), .busy_o(busy_o),
    .ack_o(ack_o), .done_o(done_o), .rdata_o(rdata_o), .bus_addr_o(bus_addr_o),
    .bus_len_o(bus_len_o), .bus_read_o(bus_read_o), .bus_start_o(bus_start_o),
    .bus_cyc_o(bus_cyc_o), .bus_dout_o(bus_dout_o), .bus_din_i(bus_din_i),
    .port_ack_i(port_ack_i), .sync_ack_i(sync_ack_i), .burst_req_o(burst_req_o),
    .burst_ack_i(burst_ack_i)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(logic [31:0] a);
    return 8'(a[7:0] * 8'd7 + 8'h13);
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] a, int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[(n-1-k)*8 +: 8] = fmem(a + 32'(k));
    return r;
  endfunction

  // device model
  int dev_pw = 4, dev_wait = 0, cnt = 0, wcnt = 0;
  bit dev_sync = 1'b0, dev_back = 1'b0;
  logic [7:0] wmem [16];

  always @(negedge clk) begin
    logic [31:0] b, a;
    int rem;
    if (bus_start_o) cnt = 0;
    else if (bus_cyc_o) cnt = cnt + 1;
    else cnt = 0;
    port_ack_i = 2'b00; sync_ack_i = 1'b0; burst_ack_i = 1'b0; bus_din_i = '0;
    if (bus_cyc_o && !bus_start_o && cnt >= 1 + dev_wait) begin
      if (dev_sync) begin
        sync_ack_i  = 1'b1;
        burst_ack_i = dev_back;
      end else port_ack_i = (dev_pw == 1) ? 2'b01 : (dev_pw == 2) ? 2'b10 : 2'b11;
      b = bus_addr_o & ~32'(dev_pw - 1);
      rem = (bus_len_o == 2'b00) ? 4 : int'(bus_len_o);
      for (int j = 0; j < dev_pw; j++) begin
        a = b + 32'(j);
        bus_din_i[(3-j)*8 +: 8] = fmem(a);
        if (!bus_read_o && a >= bus_addr_o && a < bus_addr_o + 32'(rem)) begin
          wmem[a[3:0]] = bus_dout_o[(3-j)*8 +: 8];
          wcnt++;
        end
      end
    end
  end

  // observations
  logic [31:0] o_data [4];
  logic [1:0]  o_len [16];
  logic [31:0] o_addr [16];
  int n_ack, n_start, lat;
  logic [1:0]  e_len [16];
  logic [31:0] e_addr [16];
  int e_starts;

  task automatic exp_build(input logic [31:0] a, input int n, input int pw,
                           input bit bst, input bit syn, input bit bk);
    e_starts = 0;
    if (bst && syn && bk) begin
      e_len[0] = 2'b00; e_addr[0] = a; e_starts = 1;
    end else begin
      for (int it = 0; it < (bst ? 4 : 1); it++) begin
        logic [31:0] x;
        int rem;
        x = a + 32'(4*it);
        rem = bst ? 4 : n;
        while (rem > 0) begin
          int o, t;
          o = int'(x[1:0]) % pw;
          t = pw - o;
          if (t > rem) t = rem;
          e_len[e_starts] = 2'(rem);
          e_addr[e_starts] = x;
          e_starts++;
          x = x + 32'(t);
          rem = rem - t;
        end
      end
    end
  endtask

  task automatic run(input bit we, input logic [31:0] a, input logic [1:0] sz,
                     input bit bst, input logic [31:0] wd);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; burst_i = bst; wdata_i = wd;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    n_ack = 0; n_start = 0; lat = 0;
    for (int guard = 0; guard < 300; guard++) begin
      if (bus_start_o) begin
        if (n_start < 16) begin o_len[n_start] = bus_len_o; o_addr[n_start] = bus_addr_o; end
        n_start++;
      end
      if (ack_o) begin
        if (n_ack < 4) o_data[n_ack] = rdata_o;
        n_ack++;
      end
      if (done_o) break;
      if (guard == 299) chk(1'b0, "R10", "request never finished", 32'(lat), 32'd0);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!bus_cyc_o && !bus_start_o && !busy_o && !ack_o && !done_o, "R1", "outputs in reset",
        {27'd0, bus_cyc_o, bus_start_o, busy_o, ack_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    begin
      int starts;
      starts = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (bus_start_o || busy_o) starts++;
      end
      chk(starts == 0, "R1", "idle without request", 32'(starts), 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] a, wd;
      int n, explat;
      v = VECS[i];
      a = BASE + 32'(v.lo);
      n = (v.sz == 2'b00) ? 4 : int'(v.sz);
      wd = 32'hA1B2_C3D4 ^ 32'(i * 32'h0101_0101);
      dev_pw = int'(v.pw); dev_sync = v.syn; dev_wait = int'(v.wt); dev_back = v.bk;
      wcnt = 0;
      for (int j = 0; j < 16; j++) wmem[j] = 8'h00;
      exp_build(a, n, dev_pw, v.bst, v.syn, v.bk);
      run(v.we, a, v.sz, v.bst, wd);

      chk(n_start == e_starts, vec_tag(i), "cycle count", 32'(n_start), 32'(e_starts));
      for (int s = 0; s < e_starts && s < n_start && s < 16; s++) begin
        chk(o_len[s] == e_len[s], "R2", "length code", 32'(o_len[s]), 32'(e_len[s]));
        chk(o_addr[s] == e_addr[s], "R2", "cycle address", o_addr[s], e_addr[s]);
      end
      if (v.bst && v.syn && v.bk) explat = 5;
      else explat = e_starts * ((v.syn ? 2 : 3) + int'(v.wt));
      chk(lat == explat, v.bst ? "R8" : "R3", "clocks to done", 32'(lat), 32'(explat));
      chk(n_ack == (v.bst ? 4 : 1), "R10", "ack pulses", 32'(n_ack), v.bst ? 32'd4 : 32'd1);
      if (!v.we) begin
        for (int w = 0; w < (v.bst ? 4 : 1) && w < n_ack; w++) begin
          logic [31:0] e;
          e = exp_read(a + 32'(4*w), v.bst ? 4 : n);
          chk(o_data[w] == e, vec_tag(i), "read data", o_data[w], e);
        end
      end else begin
        chk(wcnt == n, "R7", "bytes written", 32'(wcnt), 32'(n));
        for (int k = 0; k < n; k++) begin
          logic [31:0] ad;
          ad = a + 32'(k);
          chk(wmem[ad[3:0]] == wd[(n-1-k)*8 +: 8], "R7", "written byte",
              32'(wmem[ad[3:0]]), 32'(wd[(n-1-k)*8 +: 8]));
        end
      end
    end

    // R1: reset in the middle of a long wait abandons the transfer
    dev_pw = 4; dev_sync = 1'b0; dev_wait = 3; dev_back = 1'b0;
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = BASE; size_i = 2'b00; burst_i = 1'b0;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!busy_o && !bus_cyc_o && !ack_o, "R1", "abandoned on reset",
        {29'd0, busy_o, bus_cyc_o, ack_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !bus_start_o, "R1", "idle after reset release",
        {30'd0, busy_o, bus_start_o}, 32'd0);

    // R11: a wait of three clocks on a 16-bit handshake port
    dev_pw = 2; dev_wait = 3;
    exp_build(BASE + 32'd2, 2, 2, 1'b0, 1'b0, 1'b0);
    run(1'b0, BASE + 32'd2, 2'b10, 1'b0, 32'd0);
    chk(lat == 6, "R11", "waited cycle length", 32'(lat), 32'd6);
    chk(o_data[0] == exp_read(BASE + 32'd2, 2), "R11", "data after wait",
        o_data[0], exp_read(BASE + 32'd2, 2));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule